// File: doc/BRIEF.md
# PLL Power-Up Mode Sequencer

This block brings a frequency-synthesis PLL out of reset and shuts it down again. It drives a 3-bit mode word. Bit 1 takes the PLL out of bypass, bit 2 releases its active-low reset, and bit 0 enables its output. On power-up it steps that word through a fixed series of codes, with timed gaps between them. In the same step that accepts an enable request, it also latches the multiplier value (L) and the VCO band select that the PLL uses. All timing is counted in clock cycles, as a number of microseconds times a cycles-per-microsecond parameter.

An elaboration parameter chooses how the block decides that the PLL is ready. If the PLL reports lock, the block polls the lock input, and a timeout abandons a PLL that never locks. If the PLL does not report lock, the block waits a fixed settle time instead. A disable request drops the PLL back to the off code in one step, from any state. The PLL is built around the block; the analog loop is not part of this design.

Top module: `pll_mode_seq`

## Requirements
- R1: An accepted enable moves mode_o through the codes 3'b000, 3'b010, 3'b110 and 3'b111, in that order. Bit 1 means bypass off, bit 2 means reset released and bit 0 means output enabled. No code is skipped, and none is visited out of order.
- R2: Code 3'b010 is held for exactly GAP_US*TICK_CYC cycles (10 us by default, twice the 5 us minimum) before reset is released. It appears on the cycle after the enable is sampled.
- R3: With HAS_LOCK_STAT=1, code 3'b110 is held until lock_i is sampled high. Code 3'b111 appears on the next cycle, and never before lock has been seen.
- R4: With HAS_LOCK_STAT=0, code 3'b110 is held for exactly FIX_WAIT_US*TICK_CYC cycles (60 us by default), and lock_i has no effect.
- R5: dis_req_i sampled high forces mode_o to 3'b000 on the next cycle from any state, and busy_o low with it. If en_req_i and dis_req_i are high together, the disable wins.
- R6: l_cfg_o loads l_val_i only on the cycle an enable is accepted while mode_o is 3'b000. At all other times it keeps its value.
- R7: vco_hi_o is 0 when l_cfg_o <= LOW_VCO_L_MAX (40 by default) and 1 when it is above.
- R8: busy_o is high from the first 3'b010 cycle until the cycle done_o pulses. done_o is high for one cycle, together with the first 3'b111 cycle. An enable that arrives while busy or while on is ignored.
- R9: With HAS_LOCK_STAT=1, if lock_i stays low for LOCK_TMO_US*TICK_CYC cycles of code 3'b110, mode_o returns to 3'b000 with no done pulse. err_o then rises and stays high until the next accepted enable clears it.
- R10: While rst_ni is low, mode_o, l_cfg_o, vco_hi_o, busy_o, done_o and err_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_req_i | input | 1 | Request to power the PLL up |
| dis_req_i | input | 1 | Request to power the PLL down (overrides everything) |
| l_val_i | input | L_W | Multiplier value to program on enable |
| lock_i | input | 1 | PLL lock indication |
| mode_o | output | 3 | {reset release, bypass off, output enable} mode word |
| l_cfg_o | output | L_W | Programmed multiplier value |
| vco_hi_o | output | 1 | VCO high-band select |
| busy_o | output | 1 | Power-up sequence in progress |
| done_o | output | 1 | One-cycle pulse when the output becomes enabled |
| err_o | output | 1 | Lock timeout occurred |

## Verification
The bench measures the exact length of the bypass-off gap and of the lock wait. A design that releases reset early or late, or that miscounts by one cycle, shows up as a wrong cycle count. It pulses enable in the middle of a sequence and while the PLL is on, and it drives enable and disable together. A design that reloads L or restarts the sequence in these cases changes l_cfg_o or the mode code. A PLL that never locks must end in the off code with err_o set and no done pulse. The next enable must clear that error. L values on both sides of the low-VCO threshold catch a band compare that is off by one.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  typedef enum logic [1:0] {ST_OFF, ST_GAP, ST_WAIT, ST_ON} seq_st_e;

  localparam logic [2:0] MODE_OFF   = 3'b000;
  localparam logic [2:0] MODE_NOBYP = 3'b010;
  localparam logic [2:0] MODE_RUN   = 3'b110;
  localparam logic [2:0] MODE_OUT   = 3'b111;

  function automatic logic [2:0] mode_of(seq_st_e s);
    case (s)
      ST_GAP:  return MODE_NOBYP;
      ST_WAIT: return MODE_RUN;
      ST_ON:   return MODE_OUT;
      default: return MODE_OFF;
    endcase
  endfunction
endpackage

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (cnt_q != '1)     cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pll_lband.sv
module pll_lband #(
  parameter int L_W     = 8,
  parameter int LOW_MAX = 40
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [L_W-1:0] l_i,
  output logic [L_W-1:0] l_o,
  output logic           vco_hi_o
);
  logic [L_W-1:0] l_q;
  logic           hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l_q  <= '0;
      hi_q <= 1'b0;
    end else if (load_i) begin
      l_q  <= l_i;
      hi_q <= (l_i > L_W'(LOW_MAX));
    end
  end

  assign l_o      = l_q;
  assign vco_hi_o = hi_q;
endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
  import pll_seq_pkg::*;
#(
  parameter bit HAS_LOCK = 1'b1,
  parameter int GAP_CYC  = 40,
  parameter int WAIT_CYC = 240,
  parameter int TMO_CYC  = 400,
  parameter int CNT_W    = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_req_i,
  input  logic             dis_req_i,
  input  logic             lock_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             cnt_clr_o,
  output logic             load_o,
  output logic [2:0]       mode_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);
  seq_st_e st_q, st_n;
  logic    done_q, err_q;
  logic    wait_ok, wait_fail, fail_evt;

  generate
    if (HAS_LOCK) begin : g_poll
      assign wait_ok   = lock_i;
      assign wait_fail = (cnt_i == CNT_W'(TMO_CYC - 1));
    end else begin : g_fixed
      logic unused_lock;
      assign unused_lock = lock_i;
      assign wait_ok     = (cnt_i == CNT_W'(WAIT_CYC - 1));
      assign wait_fail   = 1'b0;
    end
  endgenerate

  always_comb begin
    st_n     = st_q;
    load_o   = 1'b0;
    fail_evt = 1'b0;
    if (dis_req_i) begin
      st_n = ST_OFF;
    end else begin
      case (st_q)
        ST_OFF: if (en_req_i) begin
          st_n   = ST_GAP;
          load_o = 1'b1;
        end
        ST_GAP: if (cnt_i == CNT_W'(GAP_CYC - 1)) st_n = ST_WAIT;
        ST_WAIT: begin
          if (wait_ok) st_n = ST_ON;
          else if (wait_fail) begin
            st_n     = ST_OFF;
            fail_evt = 1'b1;
          end
        end
        default: st_n = st_q;
      endcase
    end
  end

  // restart the shared timer on every phase change
  assign cnt_clr_o = (st_n != st_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_OFF;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      done_q <= (st_q == ST_WAIT) && (st_n == ST_ON);
      if (load_o)        err_q <= 1'b0;
      else if (fail_evt) err_q <= 1'b1;
    end
  end

  assign mode_o = mode_of(st_q);
  assign busy_o = (st_q == ST_GAP) || (st_q == ST_WAIT);
  assign done_o = done_q;
  assign err_o  = err_q;
endmodule

// File: rtl/pll_mode_seq.sv
module pll_mode_seq #(
  parameter int TICK_CYC      = 4,
  parameter int GAP_US        = 10,
  parameter int FIX_WAIT_US   = 60,
  parameter int LOCK_TMO_US   = 100,
  parameter int L_W           = 8,
  parameter int LOW_VCO_L_MAX = 40,
  parameter bit HAS_LOCK_STAT = 1'b1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_req_i,
  input  logic           dis_req_i,
  input  logic [L_W-1:0] l_val_i,
  input  logic           lock_i,
  output logic [2:0]     mode_o,
  output logic [L_W-1:0] l_cfg_o,
  output logic           vco_hi_o,
  output logic           busy_o,
  output logic           done_o,
  output logic           err_o
);
  localparam int GAP_CYC  = GAP_US * TICK_CYC;
  localparam int WAIT_CYC = FIX_WAIT_US * TICK_CYC;
  localparam int TMO_CYC  = LOCK_TMO_US * TICK_CYC;
  localparam int MAX_A    = (GAP_CYC > WAIT_CYC) ? GAP_CYC : WAIT_CYC;
  localparam int MAX_CYC  = (MAX_A > TMO_CYC) ? MAX_A : TMO_CYC;
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt;
  logic             cnt_clr, load;

  pll_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr),
    .cnt_o (cnt)
  );

  pll_lband #(.L_W(L_W), .LOW_MAX(LOW_VCO_L_MAX)) u_lband (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .l_i     (l_val_i),
    .l_o     (l_cfg_o),
    .vco_hi_o(vco_hi_o)
  );

  pll_seq_fsm #(
    .HAS_LOCK(HAS_LOCK_STAT),
    .GAP_CYC (GAP_CYC),
    .WAIT_CYC(WAIT_CYC),
    .TMO_CYC (TMO_CYC),
    .CNT_W   (CNT_W)
  ) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_req_i (en_req_i),
    .dis_req_i(dis_req_i),
    .lock_i   (lock_i),
    .cnt_i    (cnt),
    .cnt_clr_o(cnt_clr),
    .load_o   (load),
    .mode_o   (mode_o),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .err_o    (err_o)
  );
endmodule

// File: rtl/pll_mode_seq_chk.sv
module pll_mode_seq_chk #(
  parameter int L_W      = 8,
  parameter int LOW_MAX  = 40,
  parameter int GAP_CYC  = 40,
  parameter bit HAS_LOCK = 1'b1
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           en_req_i,
  input logic           dis_req_i,
  input logic [L_W-1:0] l_val_i,
  input logic           lock_i,
  input logic [2:0]     mode_o,
  input logic [L_W-1:0] l_cfg_o,
  input logic           vco_hi_o,
  input logic           busy_o,
  input logic           done_o,
  input logic           err_o
);
  int unsigned gcnt;
  logic [L_W-1:0] unused_l;
  logic           unused_en;
  assign unused_l  = l_val_i;
  assign unused_en = en_req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              gcnt <= 0;
    else if (mode_o == 3'b010) gcnt <= gcnt + 1;
    else                      gcnt <= 0;
  end

  p_order_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'b000) |=> (mode_o == 3'b000 || mode_o == 3'b010));
  p_order_gap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'b010) |=> (mode_o == 3'b010 || mode_o == 3'b110 || mode_o == 3'b000));
  p_order_run_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'b110) |=> (mode_o == 3'b110 || mode_o == 3'b111 || mode_o == 3'b000));
  p_order_on_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'b111) |=> (mode_o == 3'b111 || mode_o == 3'b000));
  p_gap_min_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'b010 && gcnt < GAP_CYC - 1) |=> (mode_o != 3'b110));
  p_lock_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (HAS_LOCK && mode_o == 3'b110 && !lock_i) |=> (mode_o != 3'b111));
  p_dis_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_req_i |=> (mode_o == 3'b000 && !busy_o));
  p_l_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != 3'b000) |=> $stable(l_cfg_o));
  p_vco_band_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vco_hi_o == (l_cfg_o > L_W'(LOW_MAX)));
  p_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (mode_o == 3'b111 && !busy_o));
  p_err_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> (mode_o == 3'b000 && !done_o));

  always @(negedge clk_i)
    if (!rst_ni) a_reset_r10: assert (mode_o == 3'b000 && !busy_o && !done_o && !err_o);
endmodule

bind pll_mode_seq pll_mode_seq_chk #(
  .L_W     (L_W),
  .LOW_MAX (LOW_VCO_L_MAX),
  .GAP_CYC (GAP_CYC),
  .HAS_LOCK(HAS_LOCK_STAT)
) u_chk (.*);

// File: tb/sim_pll_mode_seq.sv
`timescale 1ns/100ps
module sim_pll_mode_seq;
  localparam int TICK  = 4;
  localparam int GAP_C = 10 * TICK;
  localparam int FIX_C = 60 * TICK;
  localparam int TMO_C = 100 * TICK;
  localparam int LOWV  = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en0 = 0, dis0 = 0, lock0 = 0;
  logic [7:0] l0 = '0;
  logic [2:0] mode0;
  logic [7:0] lcfg0;
  logic vco0, busy0, done0, err0;
  logic en1 = 0, dis1 = 0, lock1 = 0;
  logic [7:0] l1 = '0;
  logic [2:0] mode1;
  logic [7:0] lcfg1;
  logic vco1, busy1, done1, err1;
  int n_chk = 0, n_bad = 0;
  bit fin = 0;

  always #2.5 clk = ~clk;

  pll_mode_seq #(.TICK_CYC(TICK), .HAS_LOCK_STAT(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_req_i(en0), .dis_req_i(dis0), .l_val_i(l0),
    .lock_i(lock0), .mode_o(mode0), .l_cfg_o(lcfg0), .vco_hi_o(vco0),
    .busy_o(busy0), .done_o(done0), .err_o(err0));

  pll_mode_seq #(.TICK_CYC(TICK), .HAS_LOCK_STAT(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .en_req_i(en1), .dis_req_i(dis1), .l_val_i(l1),
    .lock_i(lock1), .mode_o(mode1), .l_cfg_o(lcfg1), .vco_hi_o(vco1),
    .busy_o(busy1), .done_o(done1), .err_o(err1));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_vco(input int l);
    return (l > LOWV) ? 1 : 0;
  endfunction

  // dly = 0 means the PLL never locks
  task automatic enable0(input logic [7:0] l, input int dly, input bit poke);
    int n;
    @(negedge clk); en0 = 1; l0 = l;
    @(negedge clk); en0 = 0; l0 = ~l;
    chk(mode0 == 3'b010, "R1 first code", mode0, 2);
    chk(busy0, "R8 busy on start", busy0, 1);
    chk(!err0, "R9 err cleared by enable", err0, 0);
    chk(lcfg0 == l, "R6 L loaded", lcfg0, l);
    chk(vco0 == exp_vco(l), "R7 vco band", vco0, exp_vco(l));
    n = 0;
    while (mode0 == 3'b010) begin
      n++;
      if (poke && n == 3) begin en0 = 1; l0 = l ^ 8'h55; end
      else en0 = 0;
      @(negedge clk);
    end
    en0 = 0;
    chk(n == GAP_C, "R2 gap length", n, GAP_C);
    chk(mode0 == 3'b110, "R1 reset release code", mode0, 6);
    chk(lcfg0 == l, "R6 L held during sequence", lcfg0, l);
    n = 0;
    while (mode0 == 3'b110) begin
      n++;
      if (n == dly) lock0 = 1;
      @(negedge clk);
    end
    if (dly != 0) begin
      chk(n == dly, "R3 lock wait length", n, dly);
      chk(mode0 == 3'b111, "R1 output code", mode0, 7);
      chk(done0 && !busy0, "R8 done with busy low", {done0, busy0}, 2);
      @(negedge clk);
      chk(!done0, "R8 done single cycle", done0, 0);
    end else begin
      chk(n == TMO_C, "R9 timeout length", n, TMO_C);
      chk(mode0 == 3'b000, "R9 back to off", mode0, 0);
      chk(err0 && !done0, "R9 err set no done", {err0, done0}, 2);
    end
  endtask

  task automatic disable0();
    @(negedge clk); dis0 = 1;
    @(negedge clk); dis0 = 0; lock0 = 0;
    chk(mode0 == 3'b000 && !busy0, "R5 disable", mode0, 0);
  endtask

  task automatic enable1(input logic [7:0] l);
    int n;
    @(negedge clk); en1 = 1; l1 = l; lock1 = 1;
    @(negedge clk); en1 = 0;
    chk(lcfg1 == l && vco1 == exp_vco(l), "R7 vco band fixed variant", vco1, exp_vco(l));
    n = 0;
    while (mode1 == 3'b010) begin n++; @(negedge clk); end
    chk(n == GAP_C, "R2 gap length fixed variant", n, GAP_C);
    n = 0;
    while (mode1 == 3'b110) begin n++; @(negedge clk); end
    chk(n == FIX_C, "R4 fixed wait ignores lock", n, FIX_C);
    chk(mode1 == 3'b111 && done1, "R4 output after fixed wait", mode1, 7);
    @(negedge clk); dis1 = 1;
    @(negedge clk); dis1 = 0; lock1 = 0;
    chk(mode1 == 3'b000, "R5 disable fixed variant", mode1, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(mode0 == 0 && !busy0 && !done0 && !err0, "R10 reset outputs", mode0, 0);
    chk(lcfg0 == 0 && !vco0, "R10 reset L", lcfg0, 0);
    rst_n = 1;
    @(negedge clk);

    enable0(8'd40, 5, 0);            // threshold: low band
    @(negedge clk); en0 = 1; l0 = 8'd99;
    @(negedge clk); en0 = 0;
    chk(mode0 == 3'b111 && !busy0, "R8 enable ignored while on", mode0, 7);
    chk(lcfg0 == 8'd40, "R6 L unchanged while on", lcfg0, 40);
    disable0();

    enable0(8'd41, 1, 1);            // just above threshold, poke mid gap
    disable0();

    @(negedge clk); en0 = 1; dis0 = 1; l0 = 8'd7;
    @(negedge clk); en0 = 0; dis0 = 0;
    chk(mode0 == 3'b000 && !busy0, "R5 disable wins over enable", mode0, 0);
    chk(lcfg0 == 8'd41, "R6 L not loaded when disable wins", lcfg0, 41);

    @(negedge clk); en0 = 1; l0 = 8'd77;
    @(negedge clk); en0 = 0;
    repeat (3) @(negedge clk);
    dis0 = 1;
    @(negedge clk); dis0 = 0;
    chk(mode0 == 3'b000 && !busy0 && !done0, "R5 abort during gap", mode0, 0);

    enable0(8'd200, 0, 0);           // never locks
    enable0(8'd10, 3, 0);            // error cleared on accept
    disable0();

    for (int i = 0; i < 20; i++) begin
      enable0(8'($urandom), 1 + int'($urandom % 30), bit'($urandom % 2));
      disable0();
    end

    enable1(8'd41);
    enable1(8'd40);

    fin = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule